// File: doc/BRIEF.md
# Ring-Compare Response Analyzer

The block judges a set of identical units under test that all receive the same test patterns. The units are laid out on a closed ring. Each unit's output is compared with the output of the next unit on the ring, and the last unit is compared with the first. Each comparator owns one result flag. The flag is sticky: once any mismatch is seen, it stays set until it is cleared. Because every unit sits between two comparators, a single faulty unit shows up as two adjacent flags. A pair of faulty units with the same fault clears only the comparator between them.

A test session has three steps. First, a synchronous clear zeroes all flags. Second, the patterns run with `cmp_en` high; `cmp_en` is held low during pipeline fill cycles so that those cycles are not judged. Third, `shift_en` is raised. The flags then act as a shift register, and `scan_out` presents one flag per clock, starting with flag 0.

The scan path is a plain serial wire with no valid/ready handshake and no back-pressure. One bit moves on every clock while `shift_en` is high. A reader that cannot keep up must lower `shift_en`, and the chain holds its position while `shift_en` is low.

Top module: `ring_cmp_analyzer`

## Requirements
- R1: While `rst_n` is low, every flag is 0 and `scan_out` is 0. The reset is asynchronous.
- R2: Unit k occupies bits `[k*UNIT_W +: UNIT_W]` of `unit_out`. Comparator k pairs unit k with unit k+1. Comparator `NUM_UNITS-1` pairs the last unit with unit 0.
- R3: In compare mode, a mismatch on comparator k in a cycle sets flag k at that clock edge. Compare mode means `cmp_en`=1, `shift_en`=0 and `clr`=0.
- R4: A set flag stays 1 through later matching compare cycles. Only `clr` or reset returns it to 0.
- R5: With `cmp_en`=0, `shift_en`=0 and `clr`=0, no flag changes, whatever the unit values.
- R6: `clr`=1 zeroes every flag at the next edge. It takes priority over shifting and comparing.
- R7: With `shift_en`=1 and `clr`=0, comparison is suspended. Each edge moves flag k+1 into flag k, and the top flag loads `scan_in`.
- R8: `scan_out` always shows flag 0. After j shifts it therefore shows what was flag j. A bit entered on `scan_in` reaches `scan_out` after exactly `NUM_UNITS` shifts.
- R9: When exactly one unit differs from all the others, exactly two flags are set afterwards: flag k-1 (modulo the ring) and flag k, where k is that unit's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all flags |
| cmp_en | input | 1 | Compare qualifier; flags are updated from comparisons only while high |
| unit_out | input | NUM_UNITS*UNIT_W | Outputs of all units under test, packed with unit 0 in the low bits |
| shift_en | input | 1 | Scan shift enable; suspends comparison |
| scan_in | input | 1 | Serial data entering the top of the chain |
| scan_out | output | 1 | Serial result, equal to flag 0 |

## Verification
The bench first targets the ring wrap. It injects a fault on unit 0 and expects flags 0 and `NUM_UNITS-1` to be set. A design that wired the last comparator to a wrong unit would instead leave that flag clear or set a neighbouring one. It also checks that a fault present during a single compare cycle is still visible after many clean cycles, which catches a flag that follows the comparator instead of latching it. Faults are driven while `cmp_en` is low and while `shift_en` is high, and both cases must leave the flags empty; a design with the wrong mode priority would record them. Finally, a known pattern is loaded through `scan_in` and read back. A design that shifted the wrong way, or whose chain was one stage too short or too long, would return that pattern reversed or shifted.

// File: rtl/ring_ora_pkg.sv
package ring_ora_pkg;

  typedef enum logic [1:0] {
    OP_HOLD    = 2'd0,
    OP_CLEAR   = 2'd1,
    OP_SHIFT   = 2'd2,
    OP_COMPARE = 2'd3
  } ora_op_e;

  // Index of the next unit on the ring.
  function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/ring_ora_ctrl.sv
module ring_ora_ctrl
  import ring_ora_pkg::*;
(
  input  logic    clr,
  input  logic    shift_en,
  input  logic    cmp_en,
  output ora_op_e op
);

  // Priority: clear, then shift, then compare.
  always_comb begin
    if (clr)           op = OP_CLEAR;
    else if (shift_en) op = OP_SHIFT;
    else if (cmp_en)   op = OP_COMPARE;
    else               op = OP_HOLD;
  end

endmodule

// File: rtl/ring_ora_cell.sv
module ring_ora_cell
  import ring_ora_pkg::*;
#(
  parameter int unsigned UNIT_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ora_op_e           op,
  input  logic [UNIT_W-1:0] own_val,
  input  logic [UNIT_W-1:0] peer_val,
  input  logic              chain_in,
  output logic              flag_q
);

  logic mismatch;
  logic flag_d;

  assign mismatch = (own_val != peer_val);

  always_comb begin
    unique case (op)
      OP_CLEAR:   flag_d = 1'b0;
      OP_SHIFT:   flag_d = chain_in;
      OP_COMPARE: flag_d = flag_q | mismatch;
      default:    flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/ring_cmp_analyzer.sv
module ring_cmp_analyzer
  import ring_ora_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned UNIT_W    = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          cmp_en,
  input  logic [NUM_UNITS*UNIT_W-1:0]   unit_out,
  input  logic                          shift_en,
  input  logic                          scan_in,
  output logic                          scan_out
);

  localparam int unsigned LAST = NUM_UNITS - 1;

  ora_op_e              op;
  logic [NUM_UNITS-1:0] flags;

  ring_ora_ctrl u_ctrl (
    .clr      (clr),
    .shift_en (shift_en),
    .cmp_en   (cmp_en),
    .op       (op)
  );

  for (genvar k = 0; k < NUM_UNITS; k++) begin : g_cell
    localparam int unsigned PEER = ring_next(k, NUM_UNITS);
    logic chain_src;

    if (k == LAST) begin : g_top
      assign chain_src = scan_in;
    end else begin : g_mid
      assign chain_src = flags[k+1];
    end

    ring_ora_cell #(.UNIT_W(UNIT_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .own_val  (unit_out[k*UNIT_W +: UNIT_W]),
      .peer_val (unit_out[PEER*UNIT_W +: UNIT_W]),
      .chain_in (chain_src),
      .flag_q   (flags[k])
    );
  end

  assign scan_out = flags[0];

endmodule

// File: rtl/ring_ora_checker.sv
module ring_ora_checker #(
  parameter int unsigned NUM_UNITS = 8,
  parameter int unsigned UNIT_W    = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        clr,
  input logic                        cmp_en,
  input logic                        shift_en,
  input logic                        scan_in,
  input logic [NUM_UNITS*UNIT_W-1:0] unit_out,
  input logic [NUM_UNITS-1:0]        flags
);

  localparam int unsigned LAST = NUM_UNITS - 1;

  logic cmp_mode;
  logic pair0_diff;
  logic wrap_diff;

  assign cmp_mode   = cmp_en && !shift_en && !clr;
  assign pair0_diff = unit_out[0 +: UNIT_W] != unit_out[UNIT_W +: UNIT_W];
  assign wrap_diff  = unit_out[LAST*UNIT_W +: UNIT_W] != unit_out[0 +: UNIT_W];

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0)); // R6

  AST_FIRST_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && pair0_diff) |=> flags[0]); // R3

  AST_WRAP_PAIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && wrap_diff) |=> flags[LAST]); // R2

  AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !shift_en) |=> ((flags & $past(flags)) == $past(flags))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !shift_en && !cmp_en) |=> $stable(flags)); // R5

  AST_SHIFT_BODY: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (flags[LAST-1:0] == $past(flags[LAST:1]))); // R7

  AST_SHIFT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (flags[LAST] == $past(scan_in))); // R8

endmodule

bind ring_cmp_analyzer ring_ora_checker #(
  .NUM_UNITS (NUM_UNITS),
  .UNIT_W    (UNIT_W)
) u_ring_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr      (clr),
  .cmp_en   (cmp_en),
  .shift_en (shift_en),
  .scan_in  (scan_in),
  .unit_out (unit_out),
  .flags    (flags)
);

// File: tb/tb_ring_cmp_analyzer.sv
`timescale 1ns/1ps
module tb_ring_cmp_analyzer;

  localparam int N = 5;
  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           clr = 1'b0;
  logic           cmp_en = 1'b0;
  logic [N*W-1:0] unit_out = '0;
  logic           shift_en = 1'b0;
  logic           scan_in = 1'b0;
  logic           scan_out;

  int checks = 0;
  int errors = 0;
  bit model [N];

  ring_cmp_analyzer #(.NUM_UNITS(N), .UNIT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cmp_en(cmp_en),
    .unit_out(unit_out), .shift_en(shift_en), .scan_in(scan_in),
    .scan_out(scan_out)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference: flags as an array, updated per requirement text.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) model[i] = 1'b0;
    end else if (clr) begin
      for (int i = 0; i < N; i++) model[i] = 1'b0;
    end else if (shift_en) begin
      for (int i = 0; i < N - 1; i++) model[i] = model[i+1];
      model[N-1] = scan_in;
    end else if (cmp_en) begin
      for (int i = 0; i < N; i++)
        if (unit_out[i*W +: W] != unit_out[((i + 1) % N)*W +: W]) model[i] = 1'b1;
    end
  end

  // Per-clock comparison of the serial output against the reference.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (scan_out !== model[0]) begin
        errors++;
        $display("FAIL R8 per-clock scan_out=%0b expected=%0b", scan_out, model[0]);
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] base, input int bad, input logic [W-1:0] badv);
    for (int k = 0; k < N; k++)
      unit_out[k*W +: W] = (k == bad) ? badv : base;
  endtask

  task automatic run(input int cycles);
    repeat (cycles) @(negedge clk);
  endtask

  task automatic readout(output logic [N-1:0] got);
    shift_en = 1'b1;
    scan_in  = 1'b0;
    for (int i = 0; i < N; i++) begin
      got[i] = scan_out;
      @(negedge clk);
    end
    shift_en = 1'b0;
  endtask

  task automatic start_session();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] got;
    logic [N-1:0] pat;
    @(negedge clk);
    chk("R1 scan_out in reset", scan_out, 0);
    run(2);
    rst_n = 1'b1;
    @(negedge clk);
    readout(got);
    chk("R1 flags after reset", got, 0);

    // R2: equal outputs under several patterns set nothing
    start_session();
    cmp_en = 1'b1;
    for (int p = 0; p < 6; p++) begin drive(4'(p * 3), -1, '0); @(negedge clk); end
    cmp_en = 1'b0;
    readout(got);
    chk("R2 all units equal", got, 0);

    // R9/R3/R4: unit 2 differs for one cycle, then clean cycles
    start_session();
    cmp_en = 1'b1;
    drive(4'h5, 2, 4'hA); @(negedge clk);
    drive(4'h5, -1, '0); run(8);
    cmp_en = 1'b0;
    readout(got);
    chk("R9 single fault unit 2", got, 5'b00110);
    chk("R4 sticky after clean cycles", got[1], 1);

    // R2 wrap: unit 0 faulty
    start_session();
    cmp_en = 1'b1;
    drive(4'h3, 0, 4'hC); @(negedge clk);
    cmp_en = 1'b0; drive(4'h3, -1, '0);
    readout(got);
    chk("R2 wrap fault unit 0", got, 5'b10001);

    // R9: last unit faulty
    start_session();
    cmp_en = 1'b1;
    drive(4'h9, N - 1, 4'h1); run(3);
    cmp_en = 1'b0; drive(4'h9, -1, '0);
    readout(got);
    chk("R9 single fault last unit", got, 5'b11000);

    // R5: mismatch with compare disabled
    start_session();
    drive(4'h0, 3, 4'hF); run(4);
    drive(4'h0, -1, '0);
    readout(got);
    chk("R5 compare disabled", got, 0);

    // R7: mismatch while shifting is not recorded
    start_session();
    cmp_en = 1'b1; shift_en = 1'b1; scan_in = 1'b0;
    drive(4'h2, 1, 4'h7); run(3);
    shift_en = 1'b0; cmp_en = 1'b0; drive(4'h2, -1, '0);
    readout(got);
    chk("R7 shift suspends compare", got, 0);

    // R6: clear wins over shift and compare
    start_session();
    cmp_en = 1'b1; drive(4'h4, 1, 4'h6); @(negedge clk);
    clr = 1'b1; shift_en = 1'b1; scan_in = 1'b1; @(negedge clk);
    clr = 1'b0; shift_en = 1'b0; cmp_en = 1'b0; drive(4'h4, -1, '0);
    readout(got);
    chk("R6 clear priority", got, 0);

    // R8: pattern through scan_in returns after N shifts in order
    start_session();
    pat = 5'b01101;
    shift_en = 1'b1;
    for (int i = 0; i < N; i++) begin scan_in = pat[i]; @(negedge clk); end
    shift_en = 1'b0; scan_in = 1'b0;
    chk("R8 first loaded bit at scan_out", scan_out, pat[0]);
    run(3);
    chk("R7 chain holds while idle", scan_out, pat[0]);
    readout(got);
    chk("R8 scan chain length and order", got, pat);

    // R4: flags survive idle cycles and mid-readout pause
    start_session();
    cmp_en = 1'b1; drive(4'h8, 3, 4'h0); @(negedge clk);
    cmp_en = 1'b0; drive(4'h8, -1, '0); run(5);
    shift_en = 1'b1; run(2); shift_en = 1'b0; run(2);
    chk("R8 flag 2 after two shifts", scan_out, 1);

    run(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule